// File: doc/BRIEF.md
# Edge/Level Interrupt Trigger Stage

This stage conditions sixteen interrupt lines, grouped as two banks of eight, before they reach an interrupt controller's request logic. A line may be driven by several sources at once. The stage keeps a small count of outstanding assertions for each line, so a line stays active until every source that raised it has released it. Commands name a line with a 4-bit index whose top bit picks the bank. The command is an assert, a deassert, or a pulse, which is an assert followed at once by a deassert.

For each command the stage looks up the line's trigger mode in its bank's 8-bit trigger register. Bit n of a bank's register holds the mode of that bank's line n: 1 means level, 0 means edge. The stage then emits a one-cycle request-set and/or request-clear strobe for that line. The controller applies the strobes to its own request register: set first, then clear. Both trigger registers can be read and written a byte at a time. Some lines are wired to edge mode whatever is written.

Top module: `irq_trigger_stage`

## Requirements
- R1: After reset, req_set, req_clr and cnt_err are 0, and both trigger registers read 0, so every line is in edge mode.
- R2: An assert (cmd_op=2'b01) adds one to the line's count. In edge mode it strobes req_set only when the count goes from 0 to 1.
- R3: In level mode an assert always strobes req_set. A deassert (cmd_op=2'b10) that leaves the count above 0 also strobes req_set.
- R4: A deassert that takes the count from 1 to 0 strobes req_clr in level mode. In edge mode it strobes nothing.
- R5: A pulse (cmd_op=2'b11) leaves the count unchanged. It strobes req_set when the count is 0 or the line is level. It also strobes req_clr when the count is 0 and the line is level.
- R6: A deassert on a count of 0 strobes cnt_err and no set or clear. The count stays at 0.
- R7: Counts are 4 bits and saturate at 15. After 17 asserts, 14 deasserts leave the count above 0, and the 15th takes it to 0.
- R8: A write to bank 0's trigger register stores the written value ANDed with 0xF8. Its lines 0 to 2 therefore stay in edge mode.
- R9: A write to bank 1's trigger register stores the written value ANDed with 0xDE. Its lines 0 and 5 therefore stay in edge mode.
- R10: Register accesses take effect only when reg_bytes is 1. Any other size writes nothing and reads back 0.
- R11: A command to a bank whose bank_ready bit is 0 changes no count and produces no strobe and no error.
- R12: Strobes appear one cycle after the command. They appear on bit cmd_line of req_set/req_clr, where bits 15:8 belong to bank 1 (cmd_line[3]=1). At most one bit is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 00 none, 01 assert, 10 deassert, 11 pulse |
| cmd_line | input | 4 | Line index; bit 3 selects the bank |
| bank_ready | input | 2 | Per-bank controller ready |
| reg_wr | input | 1 | Trigger register write |
| reg_rd | input | 1 | Trigger register read |
| reg_bank | input | 1 | Trigger register bank select |
| reg_bytes | input | 3 | Access size in bytes; only 1 is accepted |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| req_set | output | 16 | Request-set strobes, one bit per line |
| req_clr | output | 16 | Request-clear strobes, one bit per line |
| cnt_err | output | 1 | Count underflow strobe |

## Verification
The hardest state to reach is the top of the count range. No port shows the count. Saturation is therefore shown by a run of 17 asserts on a level line, followed by deasserts: no clear may appear until the 15th. Counts held at 0 after an underflow, and commands dropped while a bank is not ready, are shown the same way. A later command then reveals, through its set or error strobe, what the count must have been.

// File: rtl/irq_trigger_stage.sv
module irq_trigger_stage #(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cmd_op,
  input  logic [3:0]  cmd_line,
  input  logic [1:0]  bank_ready,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_bank,
  input  logic [2:0]  reg_bytes,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [15:0] req_set,
  output logic [15:0] req_clr,
  output logic        cnt_err
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [7:0] MASK0 = 8'hF8;
  localparam logic [7:0] MASK1 = 8'hDE;

  logic [7:0]       trig [2];
  logic [CNT_W-1:0] cnt [16];

  logic             bank, go, lvl, s, k, e;
  logic [CNT_W-1:0] c, nxt;
  logic             byte_ok;

  assign bank    = cmd_line[3];
  assign go      = (cmd_op != 2'b00) && bank_ready[bank];
  assign c       = cnt[cmd_line];
  assign lvl     = trig[bank][cmd_line[2:0]];
  assign byte_ok = (reg_bytes == 3'd1);
  assign reg_rdata = (reg_rd && byte_ok) ? trig[reg_bank] : 8'h00;

  always_comb begin
    nxt = c;
    s = 1'b0;
    k = 1'b0;
    e = 1'b0;
    case (cmd_op)
      2'b01: begin
        nxt = (c == CMAX) ? c : c + ONE;
        s   = (c == '0) || lvl;
      end
      2'b10: begin
        if (c == '0) begin
          e = 1'b1;
        end else begin
          nxt = c - ONE;
          s   = lvl && (c > ONE);
          k   = lvl && (c == ONE);
        end
      end
      2'b11: begin
        s = (c == '0) || lvl;
        k = (c == '0) && lvl;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_set <= '0;
      req_clr <= '0;
      cnt_err <= 1'b0;
      trig[0] <= '0;
      trig[1] <= '0;
      for (int i = 0; i < 16; i++) cnt[i] <= '0;
    end else begin
      req_set <= (go && s) ? (16'h0001 << cmd_line) : 16'h0000;
      req_clr <= (go && k) ? (16'h0001 << cmd_line) : 16'h0000;
      cnt_err <= go && e;
      if (go) cnt[cmd_line] <= nxt;
      if (reg_wr && byte_ok)
        trig[reg_bank] <= reg_wdata & (reg_bank ? MASK1 : MASK0);
    end
  end
endmodule

// File: rtl/irq_trigger_stage_chk.sv
module irq_trigger_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cmd_op,
  input logic [3:0]  cmd_line,
  input logic [1:0]  bank_ready,
  input logic        reg_rd,
  input logic        reg_bank,
  input logic [2:0]  reg_bytes,
  input logic [7:0]  reg_rdata,
  input logic [15:0] req_set,
  input logic [15:0] req_clr,
  input logic        cnt_err
);
  a_r12_set_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_set) && $onehot0(req_clr));

  a_r11_not_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 2'b00 && !bank_ready[cmd_line[3]]) |=> (req_set == 16'h0 && req_clr == 16'h0 && !cnt_err));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b00) |=> (req_set == 16'h0 && req_clr == 16'h0 && !cnt_err));

  a_r6_err_after_deassert: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b10 && rst_n) |=> (!cnt_err || req_set == 16'h0));

  a_r4_clr_not_on_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b01) |=> (req_clr == 16'h0 && !cnt_err));

  a_r8_bank0_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_bytes == 3'd1 && !reg_bank) |-> (reg_rdata[2:0] == 3'b000));

  a_r9_bank1_fixed_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_bytes == 3'd1 && reg_bank) |-> (reg_rdata[0] == 1'b0 && reg_rdata[5] == 1'b0));

  a_r10_bad_size_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_bytes != 3'd1) |-> (reg_rdata == 8'h00));
endmodule

bind irq_trigger_stage irq_trigger_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_line(cmd_line),
  .bank_ready(bank_ready), .reg_rd(reg_rd), .reg_bank(reg_bank),
  .reg_bytes(reg_bytes), .reg_rdata(reg_rdata), .req_set(req_set),
  .req_clr(req_clr), .cnt_err(cnt_err)
);

// File: tb/irq_trigger_stage_bench.sv
module irq_trigger_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [3:0]  cmd_line = 4'd0;
  logic [1:0]  bank_ready = 2'b11;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_bank = 1'b0;
  logic [2:0]  reg_bytes = 3'd1;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] req_set, req_clr;
  logic        cnt_err;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_trigger_stage u_irq_trigger_stage (.*);

  localparam logic [1:0] A = 2'b01, D = 2'b10, P = 2'b11;
  // op, line, exp_set, exp_clr, exp_err
  localparam int NV = 22;
  localparam logic [38:0] VEC [NV] = '{
    {A, 4'd0,  16'h0001, 16'h0000, 1'b0},  // R2 0->1 edge
    {A, 4'd0,  16'h0000, 16'h0000, 1'b0},  // R2 1->2 edge
    {D, 4'd0,  16'h0000, 16'h0000, 1'b0},
    {D, 4'd0,  16'h0000, 16'h0000, 1'b0},  // R4 edge 1->0
    {D, 4'd0,  16'h0000, 16'h0000, 1'b1},  // R6 underflow
    {A, 4'd0,  16'h0001, 16'h0000, 1'b0},  // R6 held at 0
    {D, 4'd0,  16'h0000, 16'h0000, 1'b0},
    {A, 4'd3,  16'h0008, 16'h0000, 1'b0},  // R3 level
    {A, 4'd3,  16'h0008, 16'h0000, 1'b0},  // R3
    {D, 4'd3,  16'h0008, 16'h0000, 1'b0},  // R3 2->1
    {D, 4'd3,  16'h0000, 16'h0008, 1'b0},  // R4 level 1->0
    {P, 4'd3,  16'h0008, 16'h0008, 1'b0},  // R5 level c=0
    {P, 4'd0,  16'h0001, 16'h0000, 1'b0},  // R5 edge c=0
    {A, 4'd9,  16'h0200, 16'h0000, 1'b0},  // R12 bank 1
    {P, 4'd9,  16'h0200, 16'h0000, 1'b0},  // R5 level c=1
    {D, 4'd9,  16'h0000, 16'h0200, 1'b0},
    {A, 4'd8,  16'h0100, 16'h0000, 1'b0},  // R9 forced edge
    {A, 4'd8,  16'h0000, 16'h0000, 1'b0},  // R9
    {D, 4'd8,  16'h0000, 16'h0000, 1'b0},
    {D, 4'd8,  16'h0000, 16'h0000, 1'b0},
    {A, 4'd13, 16'h2000, 16'h0000, 1'b0},  // R9 forced edge
    {A, 4'd13, 16'h0000, 16'h0000, 1'b0}   // R9
  };

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] ln);
    cmd_op = op; cmd_line = ln;
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic wr(input logic b, input logic [7:0] v, input logic [2:0] sz);
    reg_wr = 1'b1; reg_bank = b; reg_wdata = v; reg_bytes = sz;
    @(negedge clk);
    reg_wr = 1'b0; reg_bytes = 3'd1;
  endtask

  task automatic rd(input string tag, input logic b, input logic [2:0] sz, input logic [7:0] exp);
    reg_rd = 1'b1; reg_bank = b; reg_bytes = sz;
    #1;
    chk(tag, {25'd0, reg_rdata}, {25'd0, exp});
    reg_rd = 1'b0; reg_bytes = 3'd1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs", {req_set, req_clr, cnt_err}, 33'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after", {req_set, req_clr, cnt_err}, 33'd0);
    rd("R1 bank0 reg", 1'b0, 3'd1, 8'h00);
    rd("R1 bank1 reg", 1'b1, 3'd1, 8'h00);

    wr(1'b0, 8'hFF, 3'd2);
    rd("R10 wide write ignored", 1'b0, 3'd1, 8'h00);
    wr(1'b0, 8'hFF, 3'd1);
    rd("R8 bank0 mask", 1'b0, 3'd1, 8'hF8);
    rd("R10 wide read zero", 1'b0, 3'd4, 8'h00);
    wr(1'b1, 8'hFF, 3'd1);
    rd("R9 bank1 mask", 1'b1, 3'd1, 8'hDE);

    for (int i = 0; i < NV; i++) begin
      cmd_op = VEC[i][38:37]; cmd_line = VEC[i][36:33];
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5/R6/R9/R12 vector %0d", i),
          {req_set, req_clr, cnt_err}, VEC[i][32:0]);
    end
    cmd_op = 2'b00;
    @(negedge clk);

    bank_ready = 2'b01;
    cmd(A, 4'd9);
    chk("R11 not ready quiet", {req_set, req_clr, cnt_err}, 33'd0);
    bank_ready = 2'b11;
    cmd_op = D; cmd_line = 4'd9;
    @(negedge clk);
    chk("R11 count untouched", {req_set, req_clr, cnt_err}, {16'h0, 16'h0, 1'b1});
    cmd_op = 2'b00;

    for (int i = 0; i < 17; i++) begin
      cmd_op = A; cmd_line = 4'd3;
      @(negedge clk);
    end
    chk("R7 assert at max", {req_set, req_clr, cnt_err}, {16'h0008, 16'h0, 1'b0});
    for (int i = 0; i < 14; i++) begin
      cmd_op = D; cmd_line = 4'd3;
      @(negedge clk);
      chk($sformatf("R7 deassert %0d", i), {req_set, req_clr, cnt_err}, {16'h0008, 16'h0, 1'b0});
    end
    cmd_op = D; cmd_line = 4'd3;
    @(negedge clk);
    chk("R7 last deassert", {req_set, req_clr, cnt_err}, {16'h0, 16'h0008, 1'b0});
    cmd_op = 2'b00;
    @(negedge clk);
    chk("R12 idle quiet", {req_set, req_clr, cnt_err}, 33'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule